// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block connects an internal master to an external memory bus on which address and data share one set of pins. Each access starts with an address phase. During that phase the block drives the word address onto the shared bus and raises an address-latch strobe, so that an outside latch can hold the address. When the strobe drops, the same pins carry data: the block drives them for writes and releases them for reads. A chip select frames the data phase. An internal transfer acknowledge marks the cycle at whose end read data is sampled, or after which write data may change.

The master hands over one request through a valid/ready handshake. The request carries an address, a write flag and a length of one word or an eight-word line. The block returns each read word with a one-cycle valid pulse, and it pulses done once after the last acknowledge. For writes, the block presents the index of the word it needs, and the master answers with that word combinationally. Three configuration inputs are sampled when a request is accepted: the strobe length (1 to 4 cycles), the wait-state count (0 to 7 cycles before each acknowledge) and the address mode. In per-word mode every word gets its own address phase and chip-select assertion. In burst mode one address phase opens the whole line, and the low address outputs then step through the words.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset, ale=0, cs_n=1, ta=0, bus_oe=0, done=0, rd_valid=0 and req_ready=1.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. From the next cycle, ale stays high for cfg_strobe_len+1 consecutive cycles (code 0..3 gives 1..4 cycles). During those cycles bus_oe=1 and bus_out carries the word address.
- R3: ta and ale are never high in the same cycle, and cs_n is high whenever ale is high.
- R4: Each word's data phase begins in the cycle after its strobe ends or, in burst mode, in the cycle after the previous word's acknowledge. It holds cs_n low for cfg_wait_states cycles with ta low, then for one cycle with ta high.
- R5: In per-word mode (cfg_burst=0), a line makes 8 separate strobes and 8 separate falling edges of cs_n. Word k uses address {base[23:3], (base[2:0]+k) mod 8}.
- R6: In burst mode (cfg_burst=1), a line makes exactly one strobe, carrying the base address. cs_n stays low and ale stays low between words. In the acknowledge cycle of word k, la_low equals (base[2:0]+k) mod 8.
- R7: During read data phases bus_oe=0. The bus_in value present in an acknowledge cycle appears on rd_data with rd_valid high in the following cycle; rd_valid is low at all other times.
- R8: During write data phases bus_oe=1, and bus_out equals wr_data while wr_idx gives the word number k (0 for the first word).
- R9: After every read acknowledge that is followed by a new address phase or by the end of the request, there is one cycle with ale=0, cs_n=1 and bus_oe=0.
- R10: done pulses for one cycle, in the cycle after the final acknowledge. req_ready is low from acceptance until the request ends, and it is high again one cycle after done.
- R11: Changing the configuration inputs after acceptance has no effect on strobe length, wait states or address mode for the request in flight.
- R12: A request with req_line=0 produces exactly one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_strobe_len | input | 2 | Strobe length code, cycles = code+1 |
| cfg_wait_states | input | 3 | Wait cycles before each acknowledge |
| cfg_burst | input | 1 | 1: one address phase per line; 0: one per word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 24 | Word address of the first word |
| req_write | input | 1 | 1 for write, 0 for read |
| req_line | input | 1 | 1 for an 8-word line, 0 for one word |
| wr_data | input | 24 | Write word selected by wr_idx |
| wr_idx | output | 3 | Index of the write word currently needed |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | 24 | Read word |
| done | output | 1 | Request complete pulse |
| bus_out | output | 24 | Shared bus output value |
| bus_in | input | 24 | Shared bus input value |
| bus_oe | output | 1 | Shared bus output enable |
| ale | output | 1 | Address latch strobe |
| cs_n | output | 1 | Chip select, active low |
| la_low | output | 3 | Low-order address of the current word |
| ta | output | 1 | Internal transfer acknowledge |

## Verification
The main sequencing runs with single-word and line requests, in both address modes and both directions. The strobe and wait settings range from the shortest to the longest. Base addresses with non-zero low bits show whether word addresses wrap inside the line rather than carrying into the upper bits. A driven input value that changes every cycle separates a read capture taken in the acknowledge cycle from one taken a cycle early or late. A request whose configuration inputs are flipped right after acceptance tells a sampled configuration apart from a live one.

// File: rtl/mbs_pkg.sv
// Shared types for the multiplexed bus sequencer.
// Assumes: the four bus phases below are the only sequencer states.
package mbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_TURN = 2'd3
    } mbs_state_e;
endpackage

// File: rtl/mbs_phase_timer.sv
// Down-counter that times both the address strobe and the wait states.
// Assumes: the sequencer loads it on each phase entry; expired flags zero.
module mbs_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R4: an unloaded, non-zero count drops by exactly one each cycle.
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mbs_word_ctr.sv
// Word counter for one request: tracks word number, low address and last word.
// Assumes: LINE_WORDS is a power of two; step never coincides with start.
module mbs_word_ctr #(
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_low,
    input  logic             start_line,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] low,
    output logic             last
);
    logic [IDX_W-1:0] base_q;
    logic [IDX_W-1:0] idx_q;
    logic             line_q;

    // Capture the starting low address and length, then advance per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
            line_q <= 1'b0;
        end else if (start) begin
            base_q <= start_low;
            idx_q  <= '0;
            line_q <= start_line;
        end else if (step) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign idx  = idx_q;
    assign low  = base_q + idx_q;
    assign last = !line_q || (idx_q == IDX_W'(LINE_WORDS - 1));

    // R6: each step moves the low address on by one, wrapping in the line.
    p_low_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (low == $past(low) + 1'b1));
endmodule

// File: rtl/mbs_fsm.sv
// Phase sequencer: idle, address strobe, data phases and read turnaround.
// Assumes: config inputs are already captured by the top at acceptance,
// except stb_in, which is used on the accepting edge itself.
module mbs_fsm
    import mbs_pkg::*;
#(
    parameter int STB_W  = 2,
    parameter int WAIT_W = 3,
    localparam int TMR_W = (STB_W > WAIT_W) ? STB_W : WAIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [STB_W-1:0]  stb_in,
    input  logic [STB_W-1:0]  stb_q,
    input  logic [WAIT_W-1:0] wait_q,
    input  logic              burst_q,
    input  logic              write_q,
    input  logic              tmr_zero,
    input  logic              last,
    output mbs_state_e        state,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    output logic              step,
    output logic              done
);
    mbs_state_e state_q, state_d;
    logic       fin_q, fin_d;
    logic       done_q;
    logic [STB_W:0] addr_run_q;

    // Next-state and timer-load decisions for each phase.
    always_comb begin
        state_d  = state_q;
        fin_d    = fin_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        step     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                fin_d = 1'b0;
                if (fire) begin
                    state_d  = ST_ADDR;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(stb_in);
                end
            end
            ST_ADDR: begin
                if (tmr_zero) begin
                    state_d  = ST_DATA;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(wait_q);
                end
            end
            ST_DATA: begin
                if (tmr_zero) begin
                    if (last) begin
                        fin_d   = 1'b1;
                        state_d = write_q ? ST_IDLE : ST_TURN;
                    end else begin
                        step = 1'b1;
                        if (burst_q) begin
                            tmr_load = 1'b1;
                            tmr_val  = TMR_W'(wait_q);
                        end else if (write_q) begin
                            state_d  = ST_ADDR;
                            tmr_load = 1'b1;
                            tmr_val  = TMR_W'(stb_q);
                        end else begin
                            state_d  = ST_TURN;
                        end
                    end
                end
            end
            ST_TURN: begin
                if (fin_q) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d  = ST_ADDR;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(stb_q);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register, end-of-request flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fin_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fin_q   <= fin_d;
            done_q  <= (state_q == ST_DATA) && tmr_zero && last;
        end
    end

    // Length of the current strobe so far, kept for the strobe check.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_run_q <= '0;
        else if (state_q == ST_ADDR)
            addr_run_q <= addr_run_q + 1'b1;
        else
            addr_run_q <= '0;
    end

    assign state = state_q;
    assign done  = done_q;

    // R2: the strobe never outlasts the captured length code plus one.
    p_strobe_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |-> (addr_run_q <= {1'b0, stb_q}));

    // R9: the turnaround cycle is entered only from a data phase.
    p_turn_after_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TURN) |-> ($past(state_q) == ST_DATA));

    // R6: in burst mode a non-final acknowledge stays in the data phase.
    p_burst_no_relatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && tmr_zero && !last && burst_q) |=> (state_q == ST_DATA));
endmodule

// File: rtl/mux_bus_seq.sv
// Top of the multiplexed address/data bus sequencer.
// Captures a request and its configuration, drives the shared bus, strobe,
// chip select and acknowledge, and returns read words and a done pulse.
// Assumes: the master supplies wr_data for wr_idx combinationally, and
// the external bus driver follows bus_oe.
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int BUS_W      = 24,
    parameter int LINE_WORDS = 8,
    parameter int STB_W      = 2,
    parameter int WAIT_W     = 3,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int TMR_W     = (STB_W > WAIT_W) ? STB_W : WAIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STB_W-1:0]  cfg_strobe_len,
    input  logic [WAIT_W-1:0] cfg_wait_states,
    input  logic              cfg_burst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BUS_W-1:0]  req_addr,
    input  logic              req_write,
    input  logic              req_line,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              rd_valid,
    output logic [BUS_W-1:0]  rd_data,
    output logic              done,
    output logic [BUS_W-1:0]  bus_out,
    input  logic [BUS_W-1:0]  bus_in,
    output logic              bus_oe,
    output logic              ale,
    output logic              cs_n,
    output logic [IDX_W-1:0]  la_low,
    output logic              ta
);
    mbs_state_e             state;
    logic                   fire;
    logic [BUS_W-IDX_W-1:0] addr_hi_q;
    logic                   write_q;
    logic                   burst_q;
    logic [STB_W-1:0]       stb_q;
    logic [WAIT_W-1:0]      wait_q;
    logic                   tmr_load;
    logic [TMR_W-1:0]       tmr_val;
    logic                   tmr_zero;
    logic                   step;
    logic                   last;
    logic [IDX_W-1:0]       idx;
    logic [IDX_W-1:0]       low;
    logic                   rd_valid_q;
    logic [BUS_W-1:0]       rd_data_q;

    assign fire = req_valid && req_ready;

    // Capture address upper bits, direction and configuration at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hi_q <= '0;
            write_q   <= 1'b0;
            burst_q   <= 1'b0;
            stb_q     <= '0;
            wait_q    <= '0;
        end else if (fire) begin
            addr_hi_q <= req_addr[BUS_W-1:IDX_W];
            write_q   <= req_write;
            burst_q   <= cfg_burst;
            stb_q     <= cfg_strobe_len;
            wait_q    <= cfg_wait_states;
        end
    end

    mbs_fsm #(
        .STB_W  (STB_W),
        .WAIT_W (WAIT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .stb_in   (cfg_strobe_len),
        .stb_q    (stb_q),
        .wait_q   (wait_q),
        .burst_q  (burst_q),
        .write_q  (write_q),
        .tmr_zero (tmr_zero),
        .last     (last),
        .state    (state),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .step     (step),
        .done     (done)
    );

    mbs_phase_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    mbs_word_ctr #(
        .LINE_WORDS (LINE_WORDS)
    ) u_words (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fire),
        .start_low  (req_addr[IDX_W-1:0]),
        .start_line (req_line),
        .step       (step),
        .idx        (idx),
        .low        (low),
        .last       (last)
    );

    // Sample read data at the end of each read acknowledge cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= ta && !write_q;
            if (ta && !write_q)
                rd_data_q <= bus_in;
        end
    end

    // Decode strobe, select, acknowledge and bus drive from the phase.
    always_comb begin
        ale     = (state == ST_ADDR);
        cs_n    = (state != ST_DATA);
        ta      = (state == ST_DATA) && tmr_zero;
        bus_oe  = (state == ST_ADDR) || ((state == ST_DATA) && write_q);
        if (state == ST_ADDR)
            bus_out = {addr_hi_q, low};
        else if ((state == ST_DATA) && write_q)
            bus_out = wr_data;
        else
            bus_out = '0;
    end

    assign req_ready = (state == ST_IDLE);
    assign wr_idx    = idx;
    assign la_low    = low;
    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;

    // R3: acknowledge and strobe are exclusive.
    p_ta_ale_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ta && ale));

    // R3: chip select stays negated while the strobe is high.
    p_cs_off_in_ale_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> cs_n);

    // R7: the bus is released during read data phases.
    p_rd_oe_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !write_q) |-> !bus_oe);

    // R7: a read word is returned only right after an acknowledge.
    p_rdvalid_after_ta_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(ta));

    // R8: a write acknowledge happens with the bus driven by the write word.
    p_wr_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ta && write_q) |-> (bus_oe && bus_out == wr_data));

    // R10: done follows an acknowledge.
    p_done_after_ta_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ta));
endmodule

// File: tb/tb_mux_bus_seq.sv
// Directed bench for the multiplexed bus sequencer: one task per scenario,
// each walking the bus cycle by cycle and checking against the requirements.
module tb_mux_bus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_strobe_len = '0;
    logic [2:0]  cfg_wait_states = '0;
    logic        cfg_burst = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_line = 1'b0;
    logic [23:0] wr_data;
    logic [2:0]  wr_idx;
    logic        rd_valid;
    logic [23:0] rd_data;
    logic        done;
    logic [23:0] bus_out;
    logic [23:0] bus_in = '0;
    logic        bus_oe;
    logic        ale;
    logic        cs_n;
    logic [2:0]  la_low;
    logic        ta;

    int n_total = 0;
    int n_bad   = 0;
    int tick    = 0;

    always #10 clk = ~clk;

    // Master write-data model: one distinct word per index.
    assign wr_data = 24'hC0005A | (24'(wr_idx) << 8);

    mux_bus_seq dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_strobe_len(cfg_strobe_len), .cfg_wait_states(cfg_wait_states),
        .cfg_burst(cfg_burst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_line(req_line),
        .wr_data(wr_data), .wr_idx(wr_idx), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .bus_out(bus_out), .bus_in(bus_in), .bus_oe(bus_oe),
        .ale(ale), .cs_n(cs_n), .la_low(la_low), .ta(ta)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] wexp(input int k);
        return 24'hC0005A | (24'(k) << 8);
    endfunction

    // Runs one request and checks every cycle until done.
    task automatic run_xfer(input logic [23:0] a, input bit w, input bit line,
                            input bit burst, input int stb, input int wt,
                            input bit scramble);
        int nw, k, alerun, nruns, ncs, waitrun, cyc, exp_runs;
        bit p_ale, p_cs_n, p_rdta, seen_done, turn_chk;
        logic [23:0] rd_exp;
        logic [2:0]  lowk;
        string rs, rw, rb;
        rs = scramble ? "R11" : "R2";
        rw = scramble ? "R11" : "R4";
        rb = scramble ? "R11" : (burst ? "R6" : "R5");
        nw = line ? 8 : 1;
        k = 0; alerun = 0; nruns = 0; ncs = 0; waitrun = 0; cyc = 0;
        p_ale = 0; p_cs_n = 1; p_rdta = 0; seen_done = 0; turn_chk = 0;
        rd_exp = '0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R10", "ready before request", req_ready, 1);
        cfg_strobe_len  = 2'(stb);
        cfg_wait_states = 3'(wt);
        cfg_burst       = burst;
        req_addr = a; req_write = w; req_line = line; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 24'h0;
        if (scramble) begin
            cfg_strobe_len  = ~2'(stb);
            cfg_wait_states = ~3'(wt);
            cfg_burst       = ~burst;
        end
        chk(req_ready === 1'b0, "R10", "ready low after accept", req_ready, 0);
        while (!seen_done && cyc < 400) begin
            bus_in = 24'h800000 ^ (24'(tick) * 24'h00F3A7);
            lowk = a[2:0] + 3'(k);
            if (ale && ta) chk(0, "R3", "ta with ale", 1, 0);
            if (p_rdta || rd_valid)
                chk(rd_valid === p_rdta && rd_data === rd_exp, "R7", "read return",
                    rd_data, rd_exp);
            if (turn_chk) begin
                chk(!ale && cs_n && !bus_oe, "R9", "turnaround ale/cs_n/oe",
                    {ale, cs_n, bus_oe}, 3'b010);
                turn_chk = 0;
            end
            if (ale) begin
                alerun++;
                chk(cs_n === 1'b1, "R3", "cs_n during ale", cs_n, 1);
                chk(bus_oe === 1'b1 && bus_out === {a[23:3], lowk}, rb,
                    "address phase bus", bus_out, {a[23:3], lowk});
            end
            if (!ale && p_ale) begin
                chk(alerun == stb + 1, rs, "strobe length", alerun, stb + 1);
                chk(cs_n === 1'b0, "R4", "select after strobe", cs_n, 0);
                nruns++;
                alerun = 0;
            end
            if (!cs_n && p_cs_n) ncs++;
            if (burst && line && k > 0 && k < nw)
                chk(!cs_n && !ale, "R6", "select held between words", {cs_n, ale}, 0);
            if (done) begin
                chk(p_rdta || (w && k == nw), "R10", "done after last ack", k, nw);
                seen_done = 1;
            end
            p_rdta = 0;
            if (!cs_n && !ta) waitrun++;
            if (ta) begin
                chk(waitrun == wt, rw, "wait cycles", waitrun, wt);
                waitrun = 0;
                chk(la_low === lowk, "R6", "low address at ack", la_low, lowk);
                if (w) begin
                    chk(bus_oe === 1'b1 && bus_out === wexp(k), "R8", "write data",
                        bus_out, wexp(k));
                end else begin
                    chk(bus_oe === 1'b0, "R7", "oe off in read", bus_oe, 0);
                    rd_exp = bus_in;
                    p_rdta = 1;
                end
                k++;
                turn_chk = !w && (!burst || k == nw);
            end
            p_ale  = ale;
            p_cs_n = cs_n;
            @(negedge clk);
            cyc++;
            tick++;
        end
        exp_runs = (burst && line) ? 1 : nw;
        chk(seen_done, "R10", "done seen", seen_done, 1);
        chk(nruns == exp_runs, rb, "strobe count", nruns, exp_runs);
        chk(ncs == exp_runs, rb, "select assertions", ncs, exp_runs);
        chk(k == nw, line ? "R5" : "R12", "acknowledge count", k, nw);
        chk(done === 1'b0, "R10", "done single pulse", done, 0);
        chk(req_ready === 1'b1, "R10", "ready after done", req_ready, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ale && cs_n && !ta && !bus_oe && !done && !rd_valid && req_ready,
            "R1", "reset outputs",
            {ale, cs_n, ta, bus_oe, done, rd_valid, req_ready}, 7'b0100001);
    endtask

    task automatic t_single_read();   run_xfer(24'h12345B, 0, 0, 0, 0, 0, 0); endtask
    task automatic t_single_write();  run_xfer(24'hABCDE2, 1, 0, 1, 3, 7, 0); endtask
    task automatic t_word_line_rd();  run_xfer(24'h400005, 0, 1, 0, 1, 2, 0); endtask
    task automatic t_word_line_wr();  run_xfer(24'h7FFFF8, 1, 1, 0, 2, 0, 0); endtask
    task automatic t_burst_line_rd(); run_xfer(24'h0F0F03, 0, 1, 1, 0, 1, 0); endtask
    task automatic t_burst_line_wr(); run_xfer(24'h55AA07, 1, 1, 1, 3, 0, 0); endtask
    task automatic t_burst_fast_rd(); run_xfer(24'h200001, 0, 1, 1, 0, 0, 0); endtask
    task automatic t_cfg_capture();   run_xfer(24'h333336, 0, 1, 1, 2, 3, 1); endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #(20 * 150000);
        n_total++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single_read();
        t_single_write();
        t_word_line_rd();
        t_word_line_wr();
        t_burst_line_rd();
        t_burst_line_wr();
        t_burst_fast_rd();
        t_cfg_capture();
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule